// File: doc/BRIEF.md
# SPI Register Transaction Master with Device Wait States

This block runs one register access at a time to a security-module peripheral over a single-lane SPI link. A request gives the direction, a byte count from 1 to 64 and a 24-bit register address. The block sends a four-byte command header and then moves the data bytes. Write bytes are pulled from the user one at a time through a take strobe. Read bytes are handed back with a valid strobe. Each transaction ends with a one-cycle done or error pulse.

The peripheral may hold off the data phase. It signals this through bit 0 of the byte it returns during the last header byte. When that bit is 0, the master keeps chip select low and clocks dummy bytes until a returned byte has bit 0 set. It gives up after a timeout counted in core cycles. The peripheral may also fall asleep when the bus is quiet. So on the first access after reset, or after a long quiet spell, the master first toggles chip select as a short wake pulse, then waits a settle gap before starting the header. The SPI clock rate, the timeouts and the wake timing are all parameters counted in core clock cycles.

Top module: `spi_regxfer_master`

## Requirements
- R1: Header byte 0 is sent as {read, 1, count-1}: bit 7 is 1 for a read and 0 for a write, bit 6 is always 1, and bits 5:0 hold the byte count minus one.
- R2: Header bytes 1, 2 and 3 carry the register address bits 23:16, 15:8 and 7:0 in that order. Every byte is sent MSB first in SPI mode 0: the clock rests low, MOSI changes on the falling edge, MISO is sampled on the rising edge, and the clock stays low whenever chip select is high.
- R3: Exactly count-1+1 data bytes follow the header. For a write, `wr_take` pulses once per byte, and the byte on `wr_data` at that moment is sent. For a read, each received byte appears on `rd_data` with a one-cycle `rd_valid`, in arrival order. A read never pulses `wr_take`.
- R4: Apart from the wake pulse, chip select falls once per transaction. It stays low from the first header bit through the last data bit, including any wait-state polling.
- R5: If bit 0 of the byte received during header byte 3 is 1, the first data byte follows directly, with no poll bytes.
- R6: If that bit is 0, the master sends 0x00 poll bytes one at a time. It checks bit 0 of each received byte and starts the data phase right after the first poll byte that returns bit 0 = 1.
- R7: If polling has lasted `STALL_TIMEOUT` core cycles by the end of a poll byte that still returns bit 0 = 0, the master raises chip select and pulses `err`. No data byte is moved.
- R8: The wake pulse is issued on the first request after reset, or when chip select has been high for at least `IDLE_CYCLES` cycles. Chip select then goes low for exactly `WAKE_PULSE` cycles with no clock edges, and high for exactly `WAKE_GAP` cycles, before the header starts. Otherwise no wake pulse is issued.
- R9: `done` (success) or `err` (failure) is high for exactly one cycle. The two are never high together. Chip select is already high in that cycle. A new request is accepted only after that pulse.
- R10: After reset, chip select is high, the SPI clock is low, and `done`, `err`, `rd_valid` and `wr_take` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Start a transaction when idle |
| req_read | input | 1 | 1 = read, 0 = write |
| req_len_m1 | input | 6 | Byte count minus one |
| req_addr | input | 24 | Register address |
| wr_data | input | 8 | Next write byte, sampled when it is loaded |
| wr_take | output | 1 | Pulse: current `wr_data` has been taken |
| rd_data | output | 8 | Received data byte |
| rd_valid | output | 1 | Pulse: `rd_data` holds a new byte |
| done | output | 1 | Pulse: transaction finished |
| err | output | 1 | Pulse: wait-state timeout |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | SPI clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The bench includes a device model that decodes MOSI and returns bytes chosen per transaction. Transactions of random direction, length, address and stall depth are mixed with directed ones:
- A one-byte read and 64-byte transfers exercise the edges of the count field.
- Zero, one and several stall bytes separate the immediate data path from the polling path.
- A device that never becomes ready tells polling apart from the timeout exit.

Wake behaviour is probed three ways: the first access after reset, back-to-back accesses that must not wake, and an access after a long quiet spell. These tell whether the idle timer is cleared by bus activity and whether the pulse and gap widths are exact.

// File: rtl/spi_regxfer_pkg.sv
package spi_regxfer_pkg;

  localparam int LEN_W  = 6;
  localparam int ADDR_W = 24;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAKE_LO,
    ST_WAKE_GAP,
    ST_HDR,
    ST_STALL,
    ST_DATA
  } xfer_state_t;

  // Command header byte selected by position (0..3).
  function automatic logic [7:0] hdr_byte(input logic [1:0] sel,
                                          input logic is_rd,
                                          input logic [LEN_W-1:0] len_m1,
                                          input logic [ADDR_W-1:0] addr);
    case (sel)
      2'd0:    return {is_rd, 1'b1, len_m1};
      2'd1:    return addr[23:16];
      2'd2:    return addr[15:8];
      default: return addr[7:0];
    endcase
  endfunction

endpackage

// File: rtl/spi_regxfer_shifter.sv
// One-byte SPI mode 0 shifter; a single register holds TX bits (top) and RX bits (bottom).
module spi_regxfer_shifter #(
  parameter int CLK_HALF = 4
)(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       byte_done,
  output logic [7:0] rx_byte
);
  localparam int HC_W = $clog2(CLK_HALF + 1);

  logic [HC_W-1:0] half_cnt;
  logic [2:0]      bit_idx;
  logic            busy;
  logic [7:0]      sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_cnt  <= '0;
      bit_idx   <= '0;
      busy      <= 1'b0;
      sreg      <= '0;
      sck       <= 1'b0;
      mosi      <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (start) begin
        sreg     <= tx_byte;
        mosi     <= tx_byte[7];
        half_cnt <= '0;
        bit_idx  <= '0;
        busy     <= 1'b1;
        sck      <= 1'b0;
      end else if (busy) begin
        if (half_cnt == HC_W'(CLK_HALF - 1)) begin
          half_cnt <= '0;
          if (!sck) begin
            sck  <= 1'b1;
            sreg <= {sreg[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bit_idx == 3'd7) begin
              busy      <= 1'b0;
              byte_done <= 1'b1;
            end else begin
              bit_idx <= bit_idx + 3'd1;
              mosi    <= sreg[7];
            end
          end
        end else begin
          half_cnt <= half_cnt + HC_W'(1);
        end
      end
    end
  end

  assign rx_byte = sreg;

  // R2: the clock rests low outside a byte
  a_r2_sck_rests_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sck);
  // R2: MOSI holds while the clock is high
  a_r2_mosi_stable_high: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(mosi));

endmodule

// File: rtl/spi_regxfer_wake_timer.sv
// Tracks how long chip select has been high; flags a wake need after reset or long quiet.
module spi_regxfer_wake_timer #(
  parameter int IDLE_CYCLES = 90_000_000
)(
  input  logic clk,
  input  logic rst,
  input  logic bus_active,
  output logic wake_due
);
  localparam int IC_W = $clog2(IDLE_CYCLES + 1);

  logic [IC_W-1:0] quiet_cnt;
  logic            fresh;

  always_ff @(posedge clk) begin
    if (rst) begin
      quiet_cnt <= '0;
      fresh     <= 1'b1;
    end else if (bus_active) begin
      quiet_cnt <= '0;
      fresh     <= 1'b0;
    end else if (quiet_cnt != IC_W'(IDLE_CYCLES)) begin
      quiet_cnt <= quiet_cnt + IC_W'(1);
    end
  end

  assign wake_due = fresh || (quiet_cnt == IC_W'(IDLE_CYCLES));

  // R8: any bus activity clears the wake need
  a_r8_activity_clears: assert property (@(posedge clk) disable iff (rst)
    bus_active |=> !wake_due);

endmodule

// File: rtl/spi_regxfer_master.sv
module spi_regxfer_master #(
  parameter int CLK_HALF      = 4,
  parameter int STALL_TIMEOUT = 10_000_000,
  parameter int IDLE_CYCLES   = 90_000_000,
  parameter int WAKE_PULSE    = 100,
  parameter int WAKE_GAP      = 10_000
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_read,
  input  logic [5:0]  req_len_m1,
  input  logic [23:0] req_addr,
  input  logic [7:0]  wr_data,
  output logic        wr_take,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  output logic        done,
  output logic        err,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  import spi_regxfer_pkg::*;

  localparam int DLY_MAX = (WAKE_PULSE > WAKE_GAP) ? WAKE_PULSE : WAKE_GAP;
  localparam int DLY_W   = $clog2(DLY_MAX + 1);
  localparam int ST_W    = $clog2(STALL_TIMEOUT + 1);

  xfer_state_t       state;
  logic              rd_q;
  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  idx;
  logic [DLY_W-1:0]  dly_cnt;
  logic [ST_W-1:0]   stall_cnt;
  logic              cs_n_q;
  logic              sh_start;
  logic [7:0]        sh_tx;
  logic              sh_done;
  logic [7:0]        sh_rx;
  logic              wake_due;
  logic [7:0]        data_tx;

  assign data_tx = rd_q ? 8'h00 : wr_data;

  spi_regxfer_shifter #(.CLK_HALF(CLK_HALF)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .start     (sh_start),
    .tx_byte   (sh_tx),
    .miso      (spi_miso),
    .sck       (spi_sck),
    .mosi      (spi_mosi),
    .byte_done (sh_done),
    .rx_byte   (sh_rx)
  );

  spi_regxfer_wake_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_wake (
    .clk        (clk),
    .rst        (rst),
    .bus_active (!cs_n_q),
    .wake_due   (wake_due)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      rd_q      <= 1'b0;
      len_q     <= '0;
      addr_q    <= '0;
      idx       <= '0;
      dly_cnt   <= '0;
      stall_cnt <= '0;
      cs_n_q    <= 1'b1;
      sh_start  <= 1'b0;
      sh_tx     <= '0;
      wr_take   <= 1'b0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      sh_start <= 1'b0;
      wr_take  <= 1'b0;
      rd_valid <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            rd_q   <= req_read;
            len_q  <= req_len_m1;
            addr_q <= req_addr;
            idx    <= '0;
            cs_n_q <= 1'b0;
            if (wake_due) begin
              dly_cnt <= DLY_W'(WAKE_PULSE - 1);
              state   <= ST_WAKE_LO;
            end else begin
              sh_start <= 1'b1;
              sh_tx    <= hdr_byte(2'd0, req_read, req_len_m1, req_addr);
              state    <= ST_HDR;
            end
          end
        end
        ST_WAKE_LO: begin
          if (dly_cnt == '0) begin
            cs_n_q  <= 1'b1;
            dly_cnt <= DLY_W'(WAKE_GAP - 1);
            state   <= ST_WAKE_GAP;
          end else begin
            dly_cnt <= dly_cnt - DLY_W'(1);
          end
        end
        ST_WAKE_GAP: begin
          if (dly_cnt == '0) begin
            cs_n_q   <= 1'b0;
            sh_start <= 1'b1;
            sh_tx    <= hdr_byte(2'd0, rd_q, len_q, addr_q);
            state    <= ST_HDR;
          end else begin
            dly_cnt <= dly_cnt - DLY_W'(1);
          end
        end
        ST_HDR: begin
          if (sh_done) begin
            sh_start <= 1'b1;
            if (idx == LEN_W'(3)) begin
              idx <= '0;
              if (sh_rx[0]) begin
                sh_tx   <= data_tx;
                wr_take <= !rd_q;
                state   <= ST_DATA;
              end else begin
                sh_tx     <= 8'h00;
                stall_cnt <= '0;
                state     <= ST_STALL;
              end
            end else begin
              idx   <= idx + LEN_W'(1);
              sh_tx <= hdr_byte(idx[1:0] + 2'd1, rd_q, len_q, addr_q);
            end
          end
        end
        ST_STALL: begin
          if (stall_cnt != ST_W'(STALL_TIMEOUT))
            stall_cnt <= stall_cnt + ST_W'(1);
          if (sh_done) begin
            if (sh_rx[0]) begin
              sh_start <= 1'b1;
              sh_tx    <= data_tx;
              wr_take  <= !rd_q;
              state    <= ST_DATA;
            end else if (stall_cnt == ST_W'(STALL_TIMEOUT)) begin
              cs_n_q <= 1'b1;
              err    <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              sh_start <= 1'b1;
              sh_tx    <= 8'h00;
            end
          end
        end
        ST_DATA: begin
          if (sh_done) begin
            if (rd_q) begin
              rd_data  <= sh_rx;
              rd_valid <= 1'b1;
            end
            if (idx == len_q) begin
              cs_n_q <= 1'b1;
              done   <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              idx      <= idx + LEN_W'(1);
              sh_start <= 1'b1;
              sh_tx    <= data_tx;
              wr_take  <= !rd_q;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign spi_cs_n = cs_n_q;

  // R4: select held low through header, polling and data
  a_r4_cs_held: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HDR || state == ST_STALL || state == ST_DATA) |-> !spi_cs_n);
  // R9: completion pulses are exclusive and come with select released
  a_r9_pulse_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, err}));
  a_r9_released_at_end: assert property (@(posedge clk) disable iff (rst)
    (done || err) |-> spi_cs_n);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (done || err) |=> !(done || err));
  // R2: clock rests low while deselected
  a_r2_sck_low_deselected: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);
  // R3: strobes match the direction
  a_r3_take_on_write: assert property (@(posedge clk) disable iff (rst)
    wr_take |-> !rd_q);
  a_r3_valid_on_read: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rd_q);
  // R7: an error only leaves the polling phase
  a_r7_err_from_stall: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(state == ST_STALL));

endmodule

// File: tb/spi_regxfer_master_test.sv
module spi_regxfer_master_test;

  localparam int HALF     = 2;
  localparam int STALL_TO = 300;
  localparam int IDLE_CYC = 400;
  localparam int WPULSE   = 5;
  localparam int WGAP     = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_read = 1'b0;
  logic [5:0]  req_len_m1 = '0;
  logic [23:0] req_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        wr_take;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        done;
  logic        err;
  logic        spi_cs_n;
  logic        spi_sck;
  logic        spi_mosi;
  logic        spi_miso = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] wbuf [0:63];
  logic [7:0] rbuf [0:63];
  logic [7:0] mo   [0:95];
  int         g_stall = 0;
  bit         g_rd = 1'b0;

  always #5 clk = ~clk;

  spi_regxfer_master #(
    .CLK_HALF(HALF), .STALL_TIMEOUT(STALL_TO), .IDLE_CYCLES(IDLE_CYC),
    .WAKE_PULSE(WPULSE), .WAKE_GAP(WGAP)
  ) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_read(req_read),
    .req_len_m1(req_len_m1), .req_addr(req_addr), .wr_data(wr_data),
    .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .done(done), .err(err), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Device reply for byte position b of a select window.
  function automatic logic [7:0] slave_byte(input int b);
    if (b < 3) return 8'h00;
    if (b == 3) return (g_stall == 0) ? 8'h01 : 8'h00;
    if (b < 4 + g_stall) return (b == 3 + g_stall) ? 8'h01 : 8'h00;
    if (g_rd && (b - 4 - g_stall) < 64) return rbuf[b - 4 - g_stall];
    return 8'hC3;
  endfunction

  task automatic run_txn(input bit rd, input int len, input logic [23:0] addr,
                         input int stall_n, input bit exp_wake, input bit exp_to);
    int bits = 0, windows = 0, wakes = 0, wake_low = 0, gap = 0, low = 0;
    int takes = 0, rcnt = 0, widx = 0, cyc = 0, bad = 0;
    bit prev_cs = 1'b1, prev_sck = 1'b0, in_gap = 1'b0, fin = 1'b0;
    bit got_done = 1'b0, got_err = 1'b0, sck_bad = 1'b0, cs_end = 1'b0;
    logic [7:0] sh = '0;
    logic [7:0] tmp;
    logic [7:0] rg [0:63];
    g_stall = stall_n;
    g_rd = rd;
    for (int i = 0; i < 64; i++) begin
      wbuf[i] = 8'($urandom);
      rbuf[i] = 8'($urandom);
      rg[i] = '0;
    end
    for (int i = 0; i < 96; i++) mo[i] = 8'hxx;
    @(negedge clk);
    req_valid = 1'b1; req_read = rd; req_len_m1 = 6'(len - 1);
    req_addr = addr; wr_data = wbuf[0];
    @(negedge clk);
    req_valid = 1'b0;
    while (!fin && cyc < 20000) begin
      if (!spi_cs_n) begin
        if (prev_cs) begin bits = 0; low = 0; in_gap = 1'b0; end
        low++;
        if (spi_sck && !prev_sck) begin
          sh = {sh[6:0], spi_mosi};
          bits++;
          if (bits % 8 == 0 && bits / 8 <= 96) mo[bits / 8 - 1] = sh;
        end
        tmp = slave_byte(bits / 8);
        spi_miso = tmp[7 - (bits % 8)];
      end else begin
        if (!prev_cs) begin
          if (bits == 0) begin wakes++; wake_low = low; in_gap = 1'b1; gap = 0; end
          else windows++;
        end
        if (in_gap) gap++;
        if (spi_sck) sck_bad = 1'b1;
      end
      if (wr_take) begin
        takes++; widx++;
        if (widx < len) wr_data = wbuf[widx];
      end
      if (rd_valid) begin
        if (rcnt < 64) rg[rcnt] = rd_data;
        rcnt++;
      end
      if (done) got_done = 1'b1;
      if (err)  got_err = 1'b1;
      if (done || err) begin fin = 1'b1; cs_end = spi_cs_n; end
      prev_cs = spi_cs_n; prev_sck = spi_sck; cyc++;
      if (!fin) @(negedge clk);
    end
    chk(fin, "R9", "transaction completes", fin, 1);
    @(negedge clk);
    chk(!done && !err, "R9", "completion pulse one cycle", {done, err}, 0);
    chk(cs_end, "R9", "select high at completion", cs_end, 1);
    chk(got_done == !exp_to && got_err == exp_to, "R9", "done/err outcome",
        {got_done, got_err}, {!exp_to, exp_to});
    chk(mo[0] === {rd, 1'b1, 6'(len - 1)}, "R1", "header byte 0", mo[0],
        {rd, 1'b1, 6'(len - 1)});
    chk({mo[1], mo[2], mo[3]} === addr, "R2", "address bytes",
        {mo[1], mo[2], mo[3]}, addr);
    chk(!sck_bad, "R2", "clock low while deselected", sck_bad, 0);
    chk(windows == 1, "R4", "single select window", windows, 1);
    chk(wakes == int'(exp_wake), "R8", "wake pulse count", wakes, exp_wake);
    if (exp_wake) begin
      chk(wake_low == WPULSE, "R8", "wake low width", wake_low, WPULSE);
      chk(gap == WGAP, "R8", "wake gap width", gap, WGAP);
    end
    if (!exp_to) begin
      if (stall_n == 0)
        chk(bits == 8 * (4 + len), "R5", "bit count no stall", bits, 8 * (4 + len));
      else
        chk(bits == 8 * (4 + stall_n + len), "R6", "bit count with polls",
            bits, 8 * (4 + stall_n + len));
      bad = 0;
      for (int i = 0; i < stall_n; i++) if (mo[4 + i] !== 8'h00) bad++;
      chk(bad == 0, "R6", "poll bytes are zero", bad, 0);
      bad = 0;
      if (rd) begin
        for (int i = 0; i < len; i++) if (rg[i] !== rbuf[i]) bad++;
        chk(rcnt == len, "R3", "read byte count", rcnt, len);
        chk(bad == 0, "R3", "read data mismatches", bad, 0);
        chk(takes == 0, "R3", "no take on read", takes, 0);
      end else begin
        for (int i = 0; i < len; i++) if (mo[4 + stall_n + i] !== wbuf[i]) bad++;
        chk(takes == len, "R3", "write take count", takes, len);
        chk(bad == 0, "R3", "write data mismatches", bad, 0);
        chk(rcnt == 0, "R3", "no read strobe on write", rcnt, 0);
      end
    end else begin
      chk(takes == 0 && rcnt == 0, "R7", "no data after timeout", takes + rcnt, 0);
      chk(bits >= 8 * 5, "R7", "polled before timeout", bits, 40);
    end
  endtask

  initial begin
    #2_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk(spi_cs_n && !spi_sck && !done && !err && !rd_valid && !wr_take, "R10",
        "reset outputs", {spi_cs_n, spi_sck, done, err, rd_valid, wr_take}, 6'b100000);
    run_txn(1'b0, 4, 24'hD41800, 0, 1'b1, 1'b0);   // first access wakes
    run_txn(1'b1, 1, 24'h0000F0, 0, 1'b0, 1'b0);   // back-to-back, minimum length
    run_txn(1'b0, 64, 24'hABCDEF, 2, 1'b0, 1'b0);  // max write with polls
    run_txn(1'b1, 64, 24'h123456, 1, 1'b0, 1'b0);  // max read with one poll
    run_txn(1'b1, 8, 24'h000024, 1000, 1'b0, 1'b1); // device never ready: R7
    run_txn(1'b1, 2, 24'h000030, 0, 1'b0, 1'b0);   // recovers after error
    repeat (IDLE_CYC + 100) @(negedge clk);
    run_txn(1'b0, 3, 24'h000F04, 3, 1'b1, 1'b0);   // long idle wakes again
    for (int t = 0; t < 20; t++) begin
      int gap_n = int'($urandom % 40);
      repeat (gap_n) @(negedge clk);
      run_txn(1'($urandom), int'($urandom % 64) + 1, 24'($urandom),
              int'($urandom % 4), 1'b0, 1'b0);
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule